// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is an SPI master that a host drives through a simple 32-bit register bus. The host fills a transmit byte queue, programs a burst length and sets a start bit. The block then shifts exactly that many bytes in full duplex on the serial pins. Each received byte goes into a receive queue, and when the last byte is done the block drops the start bit and raises a completion flag. Each queue holds 64 bytes, and one burst moves at most 64 bytes.

The serial clock advances only on cycles where the supplied divided clock enable is high. Each enabled cycle produces one serial-clock edge, so one byte takes 16 enabled cycles. The clock polarity and phase bits set the idle level and the sampling edge. The chip select is driven by hardware for the length of a burst, or software can take it over and set its level directly. Completion can be seen by polling the self-clearing start bit or the sticky transfer-complete flag, and an interrupt output can be enabled on that flag.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and irq is 0. Transfer control (0x008) reads 0x00000080, interrupt status (0x014) reads 0x00000002 and FIFO status (0x01C) reads 0.
- R2: Register 0x000 reads the major version in bits [31:16] and the minor version in bits [15:0] (defaults 1 and 3).
- R3: Writing 1 to transfer control bit 31 starts a burst only when global control (0x004) has bit 0 (enable) and bit 1 (master) both set. Otherwise bit 31 still reads 0, the serial clock does not move and bit 12 of interrupt status stays 0.
- R4: A burst shifts exactly the programmed number of bytes, MSB first, with 16 serial-clock edges per byte. Every shifted byte pushes one byte onto the receive queue, and reads of 0x300 return those bytes in order in bits [7:0].
- R5: Transfer control bit 1 (CPOL) sets the idle level of spi_sclk. Transfer control bit 0 (CPHA) selects the data-sampling edge: the leading edge when it is 0, the trailing edge when it is 1. The data line changes on the opposite edge.
- R6: If the transmit queue runs empty before the burst count is reached, the block shifts 0x00 for each remaining byte and still completes the burst.
- R7: Transfer control bit 31 reads 1 while a burst runs and clears itself at the end. Interrupt status bit 12 (transfer complete) is set in the same cycle that bit 31 clears.
- R8: Writing 1 to interrupt status bit 12 clears it. Writing 0 there leaves it unchanged.
- R9: irq is 1 exactly when interrupt status bit 12 and interrupt enable (0x010) bit 12 are both 1.
- R10: When transfer control bit 6 is 0, spi_cs_n is 0 while a burst runs and 1 otherwise. When bit 6 is 1, spi_cs_n follows transfer control bit 7.
- R11: Interrupt status bit 1 reads 1 exactly when the receive queue is empty.
- R12: A write to FIFO control (0x018) with bit 31 set empties the transmit queue, and with bit 15 set empties the receive queue. Both bits read back as 0.
- R13: The burst count register (0x030) stores min(written value, 64). A burst of 0 completes at once: bit 31 reads 0 and bit 12 of interrupt status is set.
- R14: Byte writes to 0x200 push bits [7:0] into the transmit queue, and a push to a full queue is dropped. FIFO status holds the transmit count in bits [22:16] and the receive count in bits [6:0], and neither count exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x300) |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| sclk_en | input | 1 | Divided clock enable, one serial-clock edge per high cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench decodes spi_mosi at the sampling edge of each of the four clock modes. A design that used the wrong phase or bit order would fail on the first byte. It runs bursts longer than the bytes queued, so a design that stalls or repeats stale data instead of padding with zeros either hangs on the start bit or sends the wrong bytes. It also covers a 64-byte burst with 70 pushes, a count write above 64 and a zero-length burst; an off-by-one in the queue or the count clamp shows up as a wrong length or a wrong readback. A loopback with optional inversion checks that every received byte reaches the receive queue, and the tests cover a start request while the controller is disabled and the write-one-to-clear flag with its interrupt gating.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] A_VER   = 10'h000;
    localparam logic [ADDR_W-1:0] A_GCTL  = 10'h004;
    localparam logic [ADDR_W-1:0] A_XCTL  = 10'h008;
    localparam logic [ADDR_W-1:0] A_IEN   = 10'h010;
    localparam logic [ADDR_W-1:0] A_ISTA  = 10'h014;
    localparam logic [ADDR_W-1:0] A_FCTL  = 10'h018;
    localparam logic [ADDR_W-1:0] A_FSTA  = 10'h01C;
    localparam logic [ADDR_W-1:0] A_BURST = 10'h030;
    localparam logic [ADDR_W-1:0] A_TXD   = 10'h200;
    localparam logic [ADDR_W-1:0] A_RXD   = 10'h300;

    localparam int XC_GO    = 31;
    localparam int XC_CSLVL = 7;
    localparam int XC_CSSW  = 6;
    localparam int XC_CPOL  = 1;
    localparam int XC_CPHA  = 0;
    localparam int IS_DONE  = 12;
    localparam int IS_RXE   = 1;
    localparam int FC_TXCLR = 31;
    localparam int FC_RXCLR = 15;
    localparam int FS_TXPOS = 16;

    typedef struct packed {
        logic en;
        logic master;
        logic cpha;
        logic cpol;
        logic cs_sw;
        logic cs_lvl;
        logic done_flag;
        logic done_ie;
    } ctl_t;

    typedef struct packed {
        logic       run;
        logic [3:0] edge_cnt;
        logic       sclk_act;
        logic       mosi;
        logic [7:0] tx_sr;
        logic [7:0] rx_sr;
    } eng_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
    assign rdata = empty ? '0 : mem[rp_q];

    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        wp_d  = wp_q;
        rp_d  = rp_q;
        cnt_d = cnt_q;
        if (flush) begin
            wp_d  = '0;
            rp_d  = '0;
            cnt_d = '0;
        end else begin
            if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_xfer_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             start,
    input  logic [CNT_W-1:0] burst,
    input  logic             tx_empty,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    input  logic             miso,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi
);

    eng_t             q, d;
    logic [CNT_W-1:0] rem_d, rem_q;
    logic             ld, lead, smp;
    logic [7:0]       nb;

    always_comb begin
        d       = q;
        rem_d   = rem_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_data = '0;
        done    = 1'b0;
        ld      = 1'b0;
        lead    = !q.edge_cnt[0];
        smp     = lead ^ cpha;
        nb      = tx_empty ? 8'h00 : tx_data;

        if (!q.run) begin
            if (start) begin
                if (burst == '0) begin
                    done = 1'b1;
                end else begin
                    d.run      = 1'b1;
                    d.edge_cnt = '0;
                    d.sclk_act = 1'b0;
                    rem_d      = burst;
                    ld         = 1'b1;
                end
            end
        end else if (sclk_en) begin
            d.sclk_act = !q.sclk_act;
            d.edge_cnt = q.edge_cnt + 1'b1;
            if (smp) d.rx_sr = {q.rx_sr[6:0], miso};
            if (!smp && q.edge_cnt != 4'd15) begin
                d.mosi  = q.tx_sr[7];
                d.tx_sr = {q.tx_sr[6:0], 1'b0};
            end
            if (q.edge_cnt == 4'd15) begin
                rx_push = 1'b1;
                rx_data = cpha ? {q.rx_sr[6:0], miso} : q.rx_sr;
                rem_d   = rem_q - 1'b1;
                if (rem_q == CNT_W'(1)) begin
                    d.run = 1'b0;
                    done  = 1'b1;
                end else begin
                    ld = 1'b1;
                end
            end
        end

        if (ld) begin
            tx_pop = !tx_empty;
            if (!cpha) begin
                d.mosi  = nb[7];
                d.tx_sr = {nb[6:0], 1'b0};
            end else begin
                d.tx_sr = nb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            rem_q <= '0;
        end else begin
            q     <= d;
            rem_q <= rem_d;
        end
    end

    assign busy = q.run;
    assign sclk = q.sclk_act ^ cpol;
    assign mosi = q.mosi;

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int          FIFO_DEPTH = 64,
    parameter logic [15:0] VER_MAJOR  = 16'd1,
    parameter logic [15:0] VER_MINOR  = 16'd3,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sclk_en,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              irq
);

    ctl_t             ctl_d, ctl_q;
    logic [CNT_W-1:0] burst_d, burst_q;

    logic             tx_flush, rx_flush, tx_push, rx_pop;
    logic             tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             eng_busy, eng_done, go;

    // bus decode strobes
    assign tx_flush = bus_wr && bus_addr == A_FCTL && bus_wdata[FC_TXCLR];
    assign rx_flush = bus_wr && bus_addr == A_FCTL && bus_wdata[FC_RXCLR];
    assign tx_push  = bus_wr && bus_addr == A_TXD;
    assign rx_pop   = bus_rd && bus_addr == A_RXD;
    assign go       = bus_wr && bus_addr == A_XCTL && bus_wdata[XC_GO]
                      && ctl_q.en && ctl_q.master && !eng_busy;

    always_comb begin
        ctl_d   = ctl_q;
        burst_d = burst_q;
        if (bus_wr) begin
            unique case (bus_addr)
                A_GCTL: begin
                    ctl_d.en     = bus_wdata[0];
                    ctl_d.master = bus_wdata[1];
                end
                A_XCTL: begin
                    ctl_d.cpha   = bus_wdata[XC_CPHA];
                    ctl_d.cpol   = bus_wdata[XC_CPOL];
                    ctl_d.cs_sw  = bus_wdata[XC_CSSW];
                    ctl_d.cs_lvl = bus_wdata[XC_CSLVL];
                end
                A_IEN:   ctl_d.done_ie = bus_wdata[IS_DONE];
                A_ISTA:  if (bus_wdata[IS_DONE]) ctl_d.done_flag = 1'b0;
                A_BURST: burst_d = (bus_wdata > 32'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH)
                                                                 : bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (eng_done) ctl_d.done_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.cs_lvl <= 1'b1;
            burst_q      <= '0;
        end else begin
            ctl_q   <= ctl_d;
            burst_q <= burst_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_VER:  bus_rdata = {VER_MAJOR, VER_MINOR};
            A_GCTL: bus_rdata[1:0] = {ctl_q.master, ctl_q.en};
            A_XCTL: begin
                bus_rdata[XC_GO]    = eng_busy;
                bus_rdata[XC_CSLVL] = ctl_q.cs_lvl;
                bus_rdata[XC_CSSW]  = ctl_q.cs_sw;
                bus_rdata[XC_CPOL]  = ctl_q.cpol;
                bus_rdata[XC_CPHA]  = ctl_q.cpha;
            end
            A_IEN:  bus_rdata[IS_DONE] = ctl_q.done_ie;
            A_ISTA: begin
                bus_rdata[IS_DONE] = ctl_q.done_flag;
                bus_rdata[IS_RXE]  = rx_empty;
            end
            A_FSTA: begin
                bus_rdata[FS_TXPOS +: CNT_W] = tx_cnt;
                bus_rdata[CNT_W-1:0]         = rx_cnt;
            end
            A_BURST: bus_rdata[CNT_W-1:0] = burst_q;
            A_RXD:   bus_rdata[7:0] = rx_head;
            default: ;
        endcase
    end

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en),
        .cpol(ctl_q.cpol), .cpha(ctl_q.cpha),
        .start(go), .burst(burst_q),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .miso(spi_miso), .rx_push(rx_push), .rx_data(rx_byte),
        .busy(eng_busy), .done(eng_done),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    assign spi_cs_n = ctl_q.cs_sw ? ctl_q.cs_lvl : !eng_busy;
    assign irq      = ctl_q.done_flag && ctl_q.done_ie;

endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done_flag,
    input logic          ctl_on,
    input logic          cs_sw,
    input logic          cs_n,
    input logic          sclk,
    input logic          cpol,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);

    // R7: completion flag is up in the cycle the busy state drops
    a_r7_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    // R3: a burst only begins when the controller was enabled as master
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_on));

    // R10: hardware-owned chip select is active throughout a burst
    a_r10_hw_select: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_sw) |-> !cs_n);

    // R5: serial clock rests at the polarity level between bursts
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R14: neither queue holds more than its depth
    a_r14_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

endmodule

bind spi_xfer_ctrl spi_xfer_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done_flag(ctl_q.done_flag),
    .ctl_on(ctl_q.en && ctl_q.master), .cs_sw(ctl_q.cs_sw), .cs_n(spi_cs_n),
    .sclk(spi_sclk), .cpol(ctl_q.cpol), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_spi_xfer_ctrl;
    import spi_xfer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_en = 1'b0;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, irq;

    int n_chk = 0, n_fail = 0;
    int div_v = 2, div_cnt = 0;
    bit inv_b = 0, mon_on = 0, mon_cpol = 0, mon_cpha = 0, prev_sclk = 0;
    int mon_bits = 0;
    logic [7:0] mon_sr = '0;
    logic [7:0] exp_q[$];
    logic [7:0] rx_exp[$];

    always #4 clk = ~clk;

    assign spi_miso = spi_mosi ^ inv_b;

    spi_xfer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_en(sclk_en), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // divided clock enable
    always @(negedge clk) begin
        if (div_cnt >= div_v - 1) begin
            div_cnt <= 0;
            sclk_en <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1;
            sclk_en <= 1'b0;
        end
    end

    // monitor: decode spi_mosi at the mode's sampling edge and score it
    always @(negedge clk) begin
        if (mon_on && spi_sclk != prev_sclk) begin
            if ((prev_sclk == mon_cpol) ^ mon_cpha) begin
                mon_sr = {mon_sr[6:0], spi_mosi};
                mon_bits++;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) begin
                        check(0, "R4 extra byte shifted", {24'b0, mon_sr}, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(mon_sr == e, "R4/R5/R6 mosi byte", {24'b0, mon_sr}, {24'b0, e});
                    end
                end
            end
        end
        prev_sclk = spi_sclk;
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: queue a burst, push expectations, run it and drain the receive queue
    task automatic run_xfer(input int npush, input int burst, input bit cpol, input bit cpha,
                            input bit inv, input int div, input logic [7:0] seed);
        logic [31:0] r;
        logic [7:0]  b;
        int          polls;
        logic [31:0] mode;
        mode = 32'h80 | {30'b0, cpol, cpha};
        div_v = div; inv_b = inv; mon_cpol = cpol; mon_cpha = cpha;
        wr(A_XCTL, mode);
        wr(A_FCTL, 32'h8000_8000);
        exp_q.delete(); rx_exp.delete();
        for (int i = 0; i < npush; i++) begin
            b = seed + 8'(i * 29);
            wr(A_TXD, {24'b0, b});
            if (i < burst) begin
                exp_q.push_back(b);
                rx_exp.push_back(b ^ {8{inv}});
            end
        end
        for (int i = npush; i < burst; i++) begin
            exp_q.push_back(8'h00);
            rx_exp.push_back({8{inv}});
        end
        rd(A_FSTA, r);
        check(r[22:16] == 7'((npush > 64) ? 64 : npush), "R14 tx count", r, 0);
        wr(A_BURST, burst);
        mon_bits = 0; prev_sclk = spi_sclk; mon_on = 1;
        wr(A_XCTL, 32'h8000_0000 | mode);
        rd(A_XCTL, r);
        check(r[31] == 1'b1, "R7 busy bit reads 1", r, 32'h8000_0000);
        check(spi_cs_n == 1'b0, "R10 hw select active", {31'b0, spi_cs_n}, 0);
        polls = 0;
        while (r[31] && polls < 5000) begin
            rd(A_XCTL, r);
            polls++;
        end
        check(r[31] == 1'b0, "R7 busy bit self-clears", r, 0);
        check(spi_cs_n == 1'b1, "R10 hw select released", {31'b0, spi_cs_n}, 1);
        check(spi_sclk == cpol, "R5 idle level", {31'b0, spi_sclk}, {31'b0, cpol});
        rd(A_ISTA, r);
        check(r[12] == 1'b1, "R7 done flag set", r, 32'h1000);
        mon_on = 0;
        check(exp_q.size() == 0, "R4 byte count shifted", exp_q.size(), 0);
        while (rx_exp.size() > 0) begin
            b = rx_exp.pop_front();
            rd(A_RXD, r);
            check(r[7:0] == b, "R4 rx byte", r, {24'b0, b});
        end
        rd(A_ISTA, r);
        check(r[1] == 1'b1, "R11 rx empty after drain", r, 32'h2);
        wr(A_ISTA, 32'h1000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 0);
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 / R11 reset state
        check(spi_cs_n == 1 && spi_sclk == 0 && irq == 0, "R1 reset pins",
              {29'b0, spi_cs_n, spi_sclk, irq}, 32'h4);
        rd(A_XCTL, r); check(r == 32'h80, "R1 xctl reset", r, 32'h80);
        rd(A_ISTA, r); check(r == 32'h2, "R1 R11 status reset", r, 32'h2);
        rd(A_FSTA, r); check(r == 32'h0, "R1 fifo status reset", r, 0);
        rd(A_VER, r);  check(r == 32'h0001_0003, "R2 version", r, 32'h0001_0003);

        // R3 start while disabled
        wr(A_TXD, 32'h5A); wr(A_BURST, 1);
        wr(A_GCTL, 32'h1);
        wr(A_XCTL, 32'h8000_0080);
        rd(A_XCTL, r); check(r[31] == 0, "R3 start ignored when not master", r, 32'h80);
        repeat (40) @(negedge clk);
        check(spi_sclk == 0, "R3 sclk quiet", {31'b0, spi_sclk}, 0);
        rd(A_ISTA, r); check(r[12] == 0, "R3 no completion", r, 32'h2);
        wr(A_GCTL, 32'h3);

        // R4 / R5 four modes, loopback with and without inversion
        run_xfer(5, 5, 0, 0, 0, 2, 8'h3C);
        run_xfer(5, 5, 0, 1, 1, 3, 8'hA1);
        run_xfer(4, 4, 1, 0, 1, 1, 8'h07);
        run_xfer(6, 6, 1, 1, 0, 2, 8'hF0);

        // R6 underrun pads with zeros
        run_xfer(2, 6, 0, 0, 0, 2, 8'hC3);
        run_xfer(0, 3, 1, 1, 1, 1, 8'h00);

        // R14 full queue, maximum burst, extra pushes dropped
        run_xfer(70, 64, 0, 1, 0, 1, 8'h11);

        // R13 count clamp and zero-length burst
        wr(A_BURST, 100);
        rd(A_BURST, r); check(r == 64, "R13 burst clamp", r, 64);
        wr(A_BURST, 0);
        wr(A_XCTL, 32'h8000_0080);
        rd(A_XCTL, r); check(r[31] == 0, "R13 zero burst not busy", r, 32'h80);
        rd(A_ISTA, r); check(r[12] == 1, "R13 zero burst completes", r, 32'h1002);

        // R8 / R9 flag clear and interrupt gating
        check(irq == 0, "R9 irq masked", {31'b0, irq}, 0);
        wr(A_IEN, 32'h1000);
        @(negedge clk);
        check(irq == 1, "R9 irq enabled", {31'b0, irq}, 1);
        wr(A_ISTA, 32'h0);
        rd(A_ISTA, r); check(r[12] == 1, "R8 write 0 keeps flag", r, 32'h1002);
        wr(A_ISTA, 32'h1000);
        rd(A_ISTA, r); check(r[12] == 0, "R8 write 1 clears flag", r, 32'h2);
        check(irq == 0, "R9 irq drops with flag", {31'b0, irq}, 0);

        // R10 software chip select
        wr(A_XCTL, 32'h40);
        @(negedge clk);
        check(spi_cs_n == 0, "R10 sw select low", {31'b0, spi_cs_n}, 0);
        wr(A_XCTL, 32'hC0);
        @(negedge clk);
        check(spi_cs_n == 1, "R10 sw select high", {31'b0, spi_cs_n}, 1);

        // R5 idle level follows polarity
        wr(A_XCTL, 32'h82);
        @(negedge clk);
        check(spi_sclk == 1, "R5 cpol idle high", {31'b0, spi_sclk}, 1);
        wr(A_XCTL, 32'h80);

        // R12 queue resets: leave bytes in both queues, then clear each one
        wr(A_TXD, 32'h01); wr(A_TXD, 32'h02); wr(A_TXD, 32'h03);
        wr(A_BURST, 2);
        wr(A_XCTL, 32'h8000_0080);
        repeat (80) @(negedge clk);
        rd(A_FSTA, r); check(r == 32'h0001_0002, "R12 R14 counts before clear", r, 32'h0001_0002);
        wr(A_FCTL, 32'h8000_0000);
        rd(A_FSTA, r); check(r == 32'h2, "R12 tx queue cleared", r, 32'h2);
        rd(A_ISTA, r); check(r[1] == 0, "R11 rx not empty", r, 32'h1000);
        wr(A_FCTL, 32'h0000_8000);
        rd(A_FSTA, r); check(r == 32'h0, "R12 rx queue cleared", r, 0);
        rd(A_FCTL, r); check(r == 32'h0, "R12 reset bits read 0", r, 0);
        rd(A_ISTA, r); check(r[1] == 1, "R11 rx empty after clear", r, 32'h1002);

        summary();
    end

endmodule